// File: doc/BRIEF.md
# Serial Port Modem Handshake Logic

This block is the modem-control corner of one serial port. Software writes a control register whose bits drive two active-low handshake outputs toward the modem (terminal ready and request to send). The three active-low modem inputs (clear to send, data set ready, carrier detect) pass through a synchronizer. They are reported in a status register together with sticky change flags. An enabled modem-status interrupt is raised whenever any of those inputs changes.

A loop mode, chosen from the control register, parks both handshake outputs at their inactive level. It feeds the two status lines from the control bits, so software can test the path without a modem. The request-to-send pin doubles as a power-on strap: its level in the last reset cycle picks one of two configuration index base addresses, and that choice holds until the next reset.

Top module: `mdm_handshake`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rts_n` and `dtr_n` are 1 and `irq` is 0. After reset, the control and interrupt-enable registers read 0 and status bits 0 to 3 read 0.
- R2: Outside loop mode, control bit 0 set drives `dtr_n` to 0 and control bit 1 set drives `rts_n` to 0. A cleared bit leaves the pin at 1.
- R3: While control bit 4 (loop) is 1, `rts_n` and `dtr_n` are both 1, whatever control bits 0 and 1 hold.
- R4: Status bits 4, 5 and 7 read the inverse of `cts_n`, `dsr_n` and `dcd_n` after a two-flop synchronizer. Status bits 2 and 6 read 0.
- R5: A rise (0 to 1) of `cts_n`, `dsr_n` or `dcd_n` sets status bit 0, 1 or 3 respectively. A fall does not set these bits. A set bit stays set until a status read.
- R6: A status read (`rd_en` with `addr` = 2) returns the flags as they stood and clears bits 0 to 3 at the clock edge that ends the read. A rise detected at that same edge is kept set.
- R7: `irq` is 1 when interrupt-enable bit 3 is 1 and any of the three modem inputs has changed in either direction since the last status read. A status read clears the pending change. Enable bit 3 at 0 holds `irq` at 0.
- R8: In loop mode, the clear-to-send status comes from control bit 1 and the data-set-ready status comes from control bit 0, both read as asserted when the bit is 1. The `cts_n` and `dsr_n` pins are ignored. Carrier detect still follows `dcd_n`.
- R9: `cfg_index_base` is 0x3F0 if `rts_strap` was 0 in the last cycle of reset, and 0x370 if it was 1. It keeps that value until the next reset, whatever `rts_strap` does.
- R10: A write (`wr_en`) stores all 8 bits of `wdata` into the control register (`addr` = 0) or the interrupt-enable register (`addr` = 1). Reading that address returns them. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (status read clears flags) |
| addr | input | 2 | Register select: 0 control, 1 interrupt enable, 2 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| cts_n | input | 1 | Clear to send from modem, active low |
| dsr_n | input | 1 | Data set ready from modem, active low |
| dcd_n | input | 1 | Carrier detect from modem, active low |
| rts_strap | input | 1 | Level on the request-to-send pin, sampled during reset |
| rts_n | output | 1 | Request to send, active low |
| dtr_n | output | 1 | Terminal ready, active low |
| irq | output | 1 | Modem-status interrupt |
| cfg_index_base | output | 12 | Configuration index base chosen by the strap |

## Verification
Random register writes, pin toggles and status reads are mixed. This separates rises from falls: only rises set flags, but both raise the interrupt. It also checks pin levels against loop-fed levels and enabled against masked interrupts. Entering and leaving loop mode with mismatched pins checks that the source switch itself counts as a change. A directed case lands an input rise exactly on the edge that ends a status read, which tells a lost event from a kept one. Two resets with different strap levels, then strap toggling afterwards, separate a sampled strap from a live one.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int BASE_W  = 12;
    localparam int LINES   = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_IER  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Control register fields
    localparam int CTRL_DTR  = 0;
    localparam int CTRL_RTS  = 1;
    localparam int CTRL_LOOP = 4;
    // Interrupt-enable field for modem status
    localparam int IER_MDM   = 3;

    localparam logic [BASE_W-1:0] BASE_STRAP_LO = 12'h3F0;
    localparam logic [BASE_W-1:0] BASE_STRAP_HI = 12'h370;

    // Pin levels, active low as on the wires
    typedef struct packed {
        logic dcd;
        logic dsr;
        logic cts;
    } mdm_lines_t;

    function automatic logic [DATA_W-1:0] pack_status(mdm_lines_t lvl_n,
                                                      mdm_lines_t rise);
        logic [DATA_W-1:0] s;
        s    = '0;
        s[0] = rise.cts;
        s[1] = rise.dsr;
        s[3] = rise.dcd;
        s[4] = ~lvl_n.cts;
        s[5] = ~lvl_n.dsr;
        s[7] = ~lvl_n.dcd;
        return s;
    endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= RST_VAL;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl,
    input  logic             clr,
    output logic [WIDTH-1:0] flags,
    output logic             chg_pend,
    output logic             rise_any
);

    localparam logic [WIDTH-1:0] IDLE = '1;

    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] rise;
    logic [WIDTH-1:0] chg;

    always_comb begin
        rise     = lvl & ~prev_q;
        chg      = lvl ^ prev_q;
        rise_any = |rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= IDLE;
            flags    <= '0;
            chg_pend <= 1'b0;
        end else begin
            prev_q   <= lvl;
            // new events win over a clear landing on the same edge
            flags    <= (flags & ~{WIDTH{clr}}) | rise;
            chg_pend <= (chg_pend & ~clr) | (|chg);
        end
    end

endmodule

// File: rtl/mdm_strap.sv
module mdm_strap #(
    parameter int                BASE_W = 12,
    parameter logic [BASE_W-1:0] BASE0  = 12'h3F0,
    parameter logic [BASE_W-1:0] BASE1  = 12'h370
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_in,
    output logic [BASE_W-1:0] base
);

    logic sel_q;

    // tracks the pin through reset, freezes on the last reset cycle
    always_ff @(posedge clk) begin
        if (rst) sel_q <= strap_in;
    end

    assign base = sel_q ? BASE1 : BASE0;

endmodule

// File: rtl/mdm_handshake.sv
module mdm_handshake
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              dcd_n,
    input  logic              rts_strap,
    output logic              rts_n,
    output logic              dtr_n,
    output logic              irq,
    output logic [BASE_W-1:0] cfg_index_base
);

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] ier_q;
    logic              loop_q;
    logic              ier_mdm;
    logic              rd_stat;
    mdm_lines_t        pin_lvl;
    mdm_lines_t        sync_lvl;
    mdm_lines_t        eff_lvl;
    mdm_lines_t        dlt_flags;
    logic              dlt_pend;
    logic              dlt_rise_any;
    reg_sel_e          sel;

    assign sel     = reg_sel_e'(addr);
    assign rd_stat = rd_en && (sel == SEL_STAT);
    assign loop_q  = ctrl_q[CTRL_LOOP];
    assign ier_mdm = ier_q[IER_MDM];

    // register file
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ier_q  <= '0;
        end else if (wr_en) begin
            if (sel == SEL_CTRL) ctrl_q <= wdata;
            if (sel == SEL_IER)  ier_q  <= wdata;
        end
    end

    // modem inputs through the synchronizer
    always_comb begin
        pin_lvl.cts = cts_n;
        pin_lvl.dsr = dsr_n;
        pin_lvl.dcd = dcd_n;
    end

    mdm_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES),
        .RST_VAL('1)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (pin_lvl),
        .q  (sync_lvl)
    );

    // loop path replaces two of the lines
    always_comb begin
        eff_lvl = sync_lvl;
        if (loop_q) begin
            eff_lvl.cts = ~ctrl_q[CTRL_RTS];
            eff_lvl.dsr = ~ctrl_q[CTRL_DTR];
        end
    end

    mdm_delta #(
        .WIDTH(LINES)
    ) u_delta (
        .clk     (clk),
        .rst     (rst),
        .lvl     (eff_lvl),
        .clr     (rd_stat),
        .flags   (dlt_flags),
        .chg_pend(dlt_pend),
        .rise_any(dlt_rise_any)
    );

    mdm_strap #(
        .BASE_W(BASE_W),
        .BASE0 (BASE_STRAP_LO),
        .BASE1 (BASE_STRAP_HI)
    ) u_strap (
        .clk     (clk),
        .rst     (rst),
        .strap_in(rts_strap),
        .base    (cfg_index_base)
    );

    // outputs
    assign rts_n = ~(ctrl_q[CTRL_RTS] & ~loop_q);
    assign dtr_n = ~(ctrl_q[CTRL_DTR] & ~loop_q);
    assign irq   = ier_mdm & dlt_pend;

    always_comb begin
        case (sel)
            SEL_CTRL: rdata = ctrl_q;
            SEL_IER:  rdata = ier_q;
            SEL_STAT: rdata = pack_status(eff_lvl, dlt_flags);
            default:  rdata = '0;
        endcase
    end

endmodule

module mdm_handshake_chk
    import mdm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rts_n,
    input logic              dtr_n,
    input logic              irq,
    input logic              loop_q,
    input logic              ier_mdm,
    input logic              rd_stat,
    input logic [LINES-1:0]  flags,
    input logic              rise_any,
    input logic [BASE_W-1:0] cfg_index_base
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (rts_n && dtr_n && !irq));

    // R3
    loop_parks_chk: assert property (@(posedge clk) disable iff (rst)
        loop_q |-> (rts_n && dtr_n));

    // R5
    flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_stat |=> ((flags & $past(flags)) == $past(flags)));

    // R6
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !rise_any) |=> (flags == '0));

    // R6
    read_keeps_new_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && rise_any) |=> (flags != '0));

    // R7
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        !ier_mdm |-> !irq);

    // R9
    strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(cfg_index_base));

endmodule

bind mdm_handshake mdm_handshake_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .rts_n         (rts_n),
    .dtr_n         (dtr_n),
    .irq           (irq),
    .loop_q        (loop_q),
    .ier_mdm       (ier_mdm),
    .rd_stat       (rd_stat),
    .flags         (dlt_flags),
    .rise_any      (dlt_rise_any),
    .cfg_index_base(cfg_index_base)
);

// File: tb/mdm_handshake_tb.sv
module mdm_handshake_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rdata;
    logic        cts_n = 1'b1;
    logic        dsr_n = 1'b1;
    logic        dcd_n = 1'b1;
    logic        rts_strap = 1'b1;
    logic        rts_n;
    logic        dtr_n;
    logic        irq;
    logic [11:0] cfg_index_base;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // model state
    logic [7:0] m_ctrl;
    logic [7:0] m_ier;
    logic [2:0] m_flags;   // {dcd, dsr, cts}
    logic       m_pend;
    logic [2:0] m_eff;     // active-low levels {dcd, dsr, cts}

    always #(CLK_PERIOD/2) clk = ~clk;

    mdm_handshake u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cts_n(cts_n), .dsr_n(dsr_n),
        .dcd_n(dcd_n), .rts_strap(rts_strap), .rts_n(rts_n), .dtr_n(dtr_n),
        .irq(irq), .cfg_index_base(cfg_index_base)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] eff_now();
        if (m_ctrl[4]) return {dcd_n, ~m_ctrl[0], ~m_ctrl[1]};
        return {dcd_n, dsr_n, cts_n};
    endfunction

    function automatic logic [7:0] exp_status(logic [2:0] lv, logic [2:0] fl);
        return {~lv[2], 1'b0, ~lv[1], ~lv[0], fl[2], 1'b0, fl[1], fl[0]};
    endfunction

    task automatic model_step();
        logic [2:0] nw;
        nw = eff_now();
        m_flags = m_flags | (nw & ~m_eff);
        if (nw != m_eff) m_pend = 1'b1;
        m_eff = nw;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
        model_step();
    endtask

    task automatic check_outputs();
        check("R2 R3 rts_n", {15'd0, rts_n}, {15'd0, ~(m_ctrl[1] & ~m_ctrl[4])});
        check("R2 R3 dtr_n", {15'd0, dtr_n}, {15'd0, ~(m_ctrl[0] & ~m_ctrl[4])});
        check("R7 irq", {15'd0, irq}, {15'd0, m_ier[3] & m_pend});
    endtask

    task automatic do_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 2'd0) m_ctrl = d;
        if (a == 2'd1) m_ier = d;
        settle();
        check_outputs();
    endtask

    task automatic read_check(logic [1:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        check(tag, {8'd0, rdata}, {8'd0, exp});
        @(negedge clk);
        rd_en = 1'b0;
        if (a == 2'd2) begin
            m_flags = '0;
            m_pend  = 1'b0;
        end
        check("R6 R7 irq after read", {15'd0, irq}, {15'd0, m_ier[3] & m_pend});
    endtask

    task automatic set_pins(logic [2:0] v);
        @(negedge clk);
        {dcd_n, dsr_n, cts_n} = v;
        settle();
        check_outputs();
    endtask

    task automatic do_reset(logic strap_final);
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        {dcd_n, dsr_n, cts_n} = 3'b111;
        rts_strap = ~strap_final;
        repeat (3) @(negedge clk);
        rts_strap = strap_final;
        @(negedge clk);
        check("R1 rts_n in reset", {15'd0, rts_n}, 16'd1);
        check("R1 dtr_n in reset", {15'd0, dtr_n}, 16'd1);
        rst = 1'b0;
        m_ctrl = '0; m_ier = '0; m_flags = '0; m_pend = 1'b0; m_eff = 3'b111;
        #1;
        check("R1 irq after reset", {15'd0, irq}, 16'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'h00C0FFEE);

        // reset with strap high
        do_reset(1'b1);
        check("R9 strap high base", {4'd0, cfg_index_base}, 16'h0370);
        read_check(2'd0, 8'h00, "R1 ctrl reset");
        read_check(2'd1, 8'h00, "R1 ier reset");
        read_check(2'd2, exp_status(3'b111, 3'b000), "R1 R4 status reset");
        read_check(2'd3, 8'h00, "R10 unused address");

        // R2 directed
        do_write(2'd0, 8'h01);
        do_write(2'd0, 8'h02);
        do_write(2'd0, 8'h03);
        // R3 directed: loop with both bits set
        do_write(2'd0, 8'h13);
        read_check(2'd0, 8'h13, "R10 ctrl readback");
        // R8: loop feeds asserted cts/dsr, pins forced opposite
        set_pins(3'b111);
        read_check(2'd2, exp_status(m_eff, m_flags), "R8 loop status");
        do_write(2'd0, 8'h00);

        // R5 fall does not set a flag, R7 fall does raise irq
        do_write(2'd1, 8'h08);
        read_check(2'd2, exp_status(m_eff, m_flags), "R5 clear before fall");
        set_pins(3'b000);
        read_check(2'd2, exp_status(3'b000, 3'b000), "R5 fall sets nothing");
        set_pins(3'b111);
        read_check(2'd2, exp_status(3'b111, 3'b111), "R5 rise sets all flags");

        // R6 rise lands on the edge that ends a status read
        set_pins(3'b000);
        read_check(2'd2, exp_status(m_eff, m_flags), "R6 clear before race");
        @(negedge clk);
        cts_n = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b1; addr = 2'd2;
        #1;
        check("R6 read during race", {8'd0, rdata}, {8'd0, exp_status(3'b001, 3'b000)});
        @(negedge clk);
        rd_en = 1'b0;
        m_flags = '0; m_pend = 1'b0;
        model_step();
        check("R6 race irq kept", {15'd0, irq}, 16'd1);
        read_check(2'd2, exp_status(3'b001, 3'b001), "R6 race flag kept");

        // R7 masked
        do_write(2'd1, 8'h00);
        set_pins(3'b111);
        check("R7 masked irq", {15'd0, irq}, 16'd0);
        do_write(2'd1, 8'h08);
        check("R7 unmask pending", {15'd0, irq}, {15'd0, m_pend});

        // random mix
        for (int i = 0; i < N_RANDOM; i++) begin
            int unsigned op;
            op = $urandom_range(0, 9);
            if (op < 2) begin
                logic [7:0] d;
                d = 8'($urandom);
                do_write(2'd0, d);
                read_check(2'd0, d, "R10 ctrl random");
            end else if (op < 3) begin
                logic [7:0] d;
                d = 8'($urandom);
                do_write(2'd1, d);
                read_check(2'd1, d, "R10 ier random");
            end else if (op < 7) begin
                set_pins(3'($urandom));
            end else begin
                read_check(2'd2, exp_status(m_eff, m_flags), "R4 R5 R8 status random");
            end
        end

        // second reset with strap low, then strap moves
        do_reset(1'b0);
        check("R9 strap low base", {4'd0, cfg_index_base}, 16'h03F0);
        rts_strap = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 strap ignored after reset", {4'd0, cfg_index_base}, 16'h03F0);
        read_check(2'd2, exp_status(3'b111, 3'b000), "R1 status after second reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule